// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block is a privileged periodic interrupt source for a processor core. Software places a 32-bit interval into the timer with a single load command. That command writes the interval into a holding register and into a live countdown counter at the same time. The counter then steps down by one on every clock. Each time the counter would reach zero, it raises a sticky interrupt request and refills itself from the holding register, so the next period starts with no further software action.

Four commands control the interrupt side: load interval, clear request, enable and disable. A separate command writes a free-running 64-bit real-time clock. Every command is qualified by a privilege input, and a command that arrives without privilege changes nothing. All pins are plain level or single-cycle pulse signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. A command pulse is taken on the clock edge where it is high.

Top module: `interval_irq_timer`

## Requirements
- R1: After reset, `irq_o` is 0, `rtc_o` is 0, the interval and count are zero, and interrupts are disabled.
- R2: A privileged load copies `src_i[31:0]` into both the interval and the countdown; bits 63:32 are ignored. With interval N ≥ 1 loaded at edge L, expiries occur at edges L+N, L+2N, and so on; `irq_o` reflects an expiry right after its edge.
- R3: An expiry while enabled sets a pending request. `irq_o` equals that request while enabled and stays 1 until a privileged clear or disable.
- R4: A privileged clear drops the pending request; when a clear and an expiry fall on the same edge, the request ends up set.
- R5: A privileged disable forces `irq_o` to 0 and keeps any pending request; expiries during the disabled time are not recorded, while counting and reloading continue; enable and disable on the same edge leaves interrupts disabled.
- R6: An interval of zero produces no expiries until a nonzero interval is loaded.
- R7: With `priv_i` at 0, load, clear, enable, disable and clock write have no effect; the clock still increments.
- R8: A privileged clock write loads `src_i` into `rtc_o`, or 0 when `rtc_zero_i` is 1.
- R9: On every edge without a privileged clock write, `rtc_o` increments by one, wrapping from all ones to 0.
- R10: A load on the edge where an expiry would occur takes precedence, and no expiry is recorded on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_i | input | 1 | Privilege qualifier for all commands |
| cmd_load_i | input | 1 | Load interval and countdown from `src_i[31:0]` |
| cmd_clr_i | input | 1 | Clear pending request |
| cmd_en_i | input | 1 | Enable interrupts |
| cmd_dis_i | input | 1 | Disable interrupts |
| cmd_rtc_wr_i | input | 1 | Write real-time clock |
| rtc_zero_i | input | 1 | With a clock write, clear the clock instead of loading |
| src_i | input | 64 | Source operand for load and clock write |
| irq_o | output | 1 | Interrupt request |
| rtc_o | output | 64 | Real-time clock value |

## Verification
The countdown is hidden, so any error in its value or in its refill shows up only as a shift in the edge where `irq_o` rises. One period later, the next expiry lands on the wrong edge. The bench therefore pins every expected rise and fall to an exact edge across several periods, including across disable windows. A corrupted enable or pending bit shows on `irq_o` one edge after the command. A clock fault shows on `rtc_o` at the very next edge, because every step compares it to a running count.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W = 32;
  localparam int SRC_W = 64;

  typedef struct packed {
    logic load;
    logic clr;
    logic en;
    logic dis;
    logic rtc_wr;
  } tmr_cmd_t;

  localparam int CMD_N = $bits(tmr_cmd_t);
endpackage

// File: rtl/timer_cmd_gate.sv
module timer_cmd_gate
  import timer_pkg::*;
(
  input  logic     priv_i,
  input  tmr_cmd_t cmd_i,
  output tmr_cmd_t cmd_o
);
  logic [CMD_N-1:0] raw_v;
  logic [CMD_N-1:0] qual_v;

  assign raw_v = cmd_i;

  for (genvar b = 0; b < CMD_N; b++) begin : g_bit
    assign qual_v[b] = raw_v[b] & priv_i;
  end

  assign cmd_o = qual_v;
endmodule

// File: rtl/timer_countdown.sv
module timer_countdown #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] ivl_q;
  logic [W-1:0] cnt_q;
  logic         last_tick;

  assign last_tick = (cnt_q == ONE);
  assign expire_o  = last_tick && !load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      ivl_q <= val_i;
      cnt_q <= val_i;
    end else if (last_tick) begin
      cnt_q <= ivl_q;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/timer_irq_flag.sv
module timer_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic dis_i,
  output logic irq_o
);
  logic en_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (dis_i)     en_q <= 1'b0;
      else if (en_i) en_q <= 1'b1;

      if (expire_i && en_q) pend_q <= 1'b1;
      else if (clr_i)       pend_q <= 1'b0;
    end
  end

  assign irq_o = pend_q & en_q;
endmodule

// File: rtl/timer_rtc.sv
module timer_rtc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         zero_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] rtc_o
);
  logic [W-1:0] rtc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      rtc_q <= '0;
    else if (wr_i)   rtc_q <= zero_i ? '0 : val_i;
    else             rtc_q <= rtc_q + W'(1);
  end

  assign rtc_o = rtc_q;
endmodule

// File: rtl/interval_irq_timer.sv
module interval_irq_timer
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_i,
  input  logic             cmd_load_i,
  input  logic             cmd_clr_i,
  input  logic             cmd_en_i,
  input  logic             cmd_dis_i,
  input  logic             cmd_rtc_wr_i,
  input  logic             rtc_zero_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             irq_o,
  output logic [SRC_W-1:0] rtc_o
);
  tmr_cmd_t raw_cmd;
  tmr_cmd_t cmd;
  logic     expire;

  assign raw_cmd = '{load: cmd_load_i, clr: cmd_clr_i, en: cmd_en_i,
                     dis: cmd_dis_i, rtc_wr: cmd_rtc_wr_i};

  timer_cmd_gate u_gate (
    .priv_i (priv_i),
    .cmd_i  (raw_cmd),
    .cmd_o  (cmd)
  );

  timer_countdown #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (cmd.load),
    .val_i    (src_i[CNT_W-1:0]),
    .expire_o (expire)
  );

  timer_irq_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (expire),
    .clr_i    (cmd.clr),
    .en_i     (cmd.en),
    .dis_i    (cmd.dis),
    .irq_o    (irq_o)
  );

  timer_rtc #(.W(SRC_W)) u_rtc (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cmd.rtc_wr),
    .zero_i (rtc_zero_i),
    .val_i  (src_i),
    .rtc_o  (rtc_o)
  );
endmodule

// File: rtl/interval_irq_timer_chk.sv
module interval_irq_timer_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         priv_i,
  input logic         cmd_load_i,
  input logic         cmd_clr_i,
  input logic         cmd_en_i,
  input logic         cmd_dis_i,
  input logic         cmd_rtc_wr_i,
  input logic         rtc_zero_i,
  input logic [W-1:0] src_i,
  input logic         irq_o,
  input logic [W-1:0] rtc_o
);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(priv_i && (cmd_clr_i || cmd_dis_i))) |=> irq_o);

  p_dis_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i && cmd_dis_i) |=> !irq_o);

  p_nopriv_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_i && irq_o) |=> irq_o);

  p_nopriv_rtc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_i |=> (rtc_o - $past(rtc_o)) == W'(1));

  p_rtc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i && cmd_rtc_wr_i && !rtc_zero_i) |=> rtc_o == $past(src_i));

  p_rtc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i && cmd_rtc_wr_i && rtc_zero_i) |=> rtc_o == '0);

  p_rtc_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(priv_i && cmd_rtc_wr_i) |=> (rtc_o - $past(rtc_o)) == W'(1));

  // R1: the first edge out of reset leaves no request pending
  p_reset_r1: assert property (@(posedge clk)
    (rst_n && $past(!rst_n)) |-> !irq_o);
endmodule

bind interval_irq_timer interval_irq_timer_chk u_chk (.*);

// File: tb/interval_irq_timer_bench.sv
`timescale 1ns/1ps
module interval_irq_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_i = 1'b0;
  logic        cmd_load_i = 1'b0, cmd_clr_i = 1'b0, cmd_en_i = 1'b0, cmd_dis_i = 1'b0;
  logic        cmd_rtc_wr_i = 1'b0, rtc_zero_i = 1'b0;
  logic [63:0] src_i = '0;
  logic        irq_o;
  logic [63:0] rtc_o;

  always #2 clk = ~clk;

  interval_irq_timer u_interval_irq_timer (.*);

  typedef struct {
    int          cyc;
    bit          chk_irq;
    logic        exp_irq;
    logic [63:0] exp_rtc;
    string       req;
    string       rreq;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          total = 0;
  int          fails = 0;
  logic [63:0] rtc_exp = '0;
  bit          done = 0;

  // monitor: pops the items due on this edge and compares them
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.chk_irq) begin
          total++;
          if (irq_o !== e.exp_irq) begin
            fails++;
            $display("FAIL %s irq_o got %0b expected %0b (cycle %0d)", e.req, irq_o, e.exp_irq, cyc);
          end
        end
        total++;
        if (rtc_o !== e.exp_rtc) begin
          fails++;
          $display("FAIL %s rtc_o got %h expected %h (cycle %0d)", e.rreq, rtc_o, e.exp_rtc, cyc);
        end
      end
    end
  end

  // driver: applies one edge of stimulus and pushes its expectation
  task automatic step(input string req = "R3", input bit ci = 0, input logic ei = 1'b0,
                      input bit pv = 1, input bit ld = 0, input bit cl = 0,
                      input bit en = 0, input bit ds = 0, input bit wr = 0,
                      input bit zr = 0, input logic [63:0] src = '0);
    exp_t e;
    priv_i = pv; cmd_load_i = ld; cmd_clr_i = cl; cmd_en_i = en; cmd_dis_i = ds;
    cmd_rtc_wr_i = wr; rtc_zero_i = zr; src_i = src;
    if (pv && wr) rtc_exp = zr ? 64'd0 : src;
    else          rtc_exp = rtc_exp + 64'd1;
    e.cyc = cyc + 1; e.chk_irq = ci; e.exp_irq = ei; e.exp_rtc = rtc_exp; e.req = req;
    e.rreq = (!pv && wr) ? "R7" : (wr ? "R8" : "R9");
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic ei, input string req);
    for (int i = 0; i < n; i++) step(.req(req), .ci(1), .ei(ei));
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(.req("R1"), .ci(1), .ei(0));                        // reset state
    step(.req("R1"), .ci(1), .ei(0), .en(1));                // enable
    // R2: load 3 with junk in the upper half; edge L
    step(.req("R2"), .ci(1), .ei(0), .ld(1), .src(64'hFFFF_FFFF_0000_0003));
    idle(2, 1'b0, "R2");                                     // L+1, L+2
    step(.req("R2"), .ci(1), .ei(1));                        // L+3 expiry
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // L+4 clear
    step(.req("R2"), .ci(1), .ei(0));                        // L+5
    step(.req("R2"), .ci(1), .ei(1));                        // L+6 reload period
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // L+7
    step(.req("R3"), .ci(1), .ei(0));                        // L+8
    step(.req("R4"), .ci(1), .ei(1), .cl(1));                // L+9 clear meets expiry
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // L+10
    step(.req("R5"), .ci(1), .ei(0), .ds(1));                // L+11 disable
    step(.req("R5"), .ci(1), .ei(0));                        // L+12 dropped expiry
    step(.req("R5"), .ci(1), .ei(0), .en(1));                // L+13 nothing recorded
    step(.req("R5"), .ci(1), .ei(0));                        // L+14
    step(.req("R5"), .ci(1), .ei(1));                        // L+15 phase kept
    step(.req("R5"), .ci(1), .ei(0), .ds(1));                // L+16 mask
    step(.req("R5"), .ci(1), .ei(1), .en(1));                // L+17 request kept
    step(.req("R5"), .ci(1), .ei(0), .en(1), .ds(1));        // L+18 disable wins
    step(.req("R5"), .ci(1), .ei(1), .en(1));                // L+19
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // L+20
    step(.req("R3"), .ci(1), .ei(1));                        // L+21
    step(.req("R7"), .ci(1), .ei(1), .pv(0), .cl(1));        // L+22 clear ignored
    step(.req("R7"), .ci(1), .ei(1), .pv(0), .ds(1));        // L+23 disable ignored
    step(.req("R7"), .ci(1), .ei(1), .pv(0), .ld(1), .src(64'd100)); // L+24
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // L+25
    step(.req("R7"), .ci(1), .ei(0));                        // L+26
    step(.req("R7"), .ci(1), .ei(1));                        // L+27 interval still 3
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // L+28
    step(.req("R10"), .ci(1), .ei(0));                       // L+29
    step(.req("R10"), .ci(1), .ei(0), .ld(1), .src(64'd5));  // L+30 load beats expiry
    idle(4, 1'b0, "R10");                                    // M+1..M+4
    step(.req("R2"), .ci(1), .ei(1));                        // M+5
    step(.req("R4"), .ci(1), .ei(0), .cl(1));                // M+6
    step(.req("R6"), .ci(1), .ei(0), .ld(1), .src(64'd0));   // zero interval
    idle(20, 1'b0, "R6");
    step(.req("R2"), .ci(1), .ei(0), .ld(1), .src(64'd1));   // N
    step(.req("R2"), .ci(1), .ei(1));                        // N+1
    // clock writes
    step(.req("R8"), .wr(1), .src(64'h1234_5678_9ABC_DEF0));
    step(.req("R9"));
    step(.req("R8"), .wr(1), .zr(1), .src(64'h55));
    step(.req("R7"), .pv(0), .wr(1), .src(64'h77));
    step(.req("R8"), .wr(1), .src(64'hFFFF_FFFF_FFFF_FFFF));
    step(.req("R9"));                                        // wrap to 0
    step(.req("R9"));
    done = 1;
    finish_run();
  end
endmodule